// File: doc/BRIEF.md
# Mersenne Twister Word Stream Source

This block produces a stream of 32-bit pseudorandom words using the MT19937 recurrence. It keeps the 624-word generator state in an on-block array. A consumer pulls words through a valid/ready stream port with the signals `m_tdata`, `m_tvalid` and `m_tready`. Once the state is prepared, one tempered word can leave on every clock cycle for as long as the consumer keeps `m_tready` high.

The state is prepared by a seeding pass. The caller places a seed on `seed_val` and pulses `seed_start` for one cycle. The pass fills the array with a bit-serial multiplier, so it costs many cycles but very little area. `busy` is high for the whole pass, and start pulses that arrive during the pass are dropped. If no pass has run since reset and the consumer raises `m_tready`, the block seeds itself with 5489.

The state is regenerated lazily, one entry per word produced. Each word that leaves updates exactly one array entry, in place.

Top module: `mt_stream_gen`

## Requirements
- R1: A word moves only on a clock edge where `m_tvalid` and `m_tready` are both high. While `m_tvalid` is high and `m_tready` is low, `m_tvalid` stays high and `m_tdata` stays unchanged at the next edge, unless a new seed is accepted on that edge.
- R2: After seeding has completed, holding `m_tready` high gives one transfer on every cycle, with no gap between consecutive words.
- R3: When `busy` is low and `seed_start` is high, `seed_val` is taken as the seed. The state becomes s[0] = seed and s[i] = (1812433253 · (s[i-1] ^ (s[i-1] >> 30)) + i) mod 2^32 for i = 1..623. The output sequence that follows is the MT19937 sequence for that seed.
- R4: Seeding uses a one-bit-per-cycle multiplier, so `busy` stays high for at least 623·32 cycles.
- R5: `busy` is high for the whole seeding pass. `m_tvalid` is low while `busy` is high and while reset is applied, and `busy` is low during reset.
- R6: A `seed_start` pulse that arrives while `busy` is high has no effect. The pass in progress finishes with its original seed, and the later output matches that seed.
- R7: With no seeding since reset, `m_tready` high while idle starts a seeding pass with 5489, and `busy` rises at the next edge. Without `m_tready`, no pass starts. The first word after this automatic pass is 3499211612.
- R8: Each new state entry j is built from the top bit of entry j and the low 31 bits of entry (j+1) mod 624. That value is shifted right by one, XORed with entry (j+397) mod 624, and XORed again with 0x9908B0DF when its low bit is 1. The sequence stays correct across the 624-word boundaries.
- R9: Each output word is tempered in this order: y ^= y>>11; y ^= (y<<7) & 0x9D2C5680; y ^= (y<<15) & 0xEFC60000; y ^= y>>18.
- R10: Reset clears the seeded condition, so after reset the next `m_tready` starts a new automatic 5489 pass, and the first word is 3499211612 again.
- R11: A seed accepted while a word is pending withdraws that word. `m_tvalid` is low and `busy` is high at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| seed_val | input | 32 | Seed value captured with `seed_start` |
| seed_start | input | 1 | One-cycle request to start seeding |
| busy | output | 1 | High while a seeding pass runs |
| m_tdata | output | 32 | Tempered output word |
| m_tvalid | output | 1 | Output word valid |
| m_tready | input | 1 | Consumer ready; also triggers the automatic seed |

## Verification
The hardest situation to reach from the ports is the wrap of the lazy regeneration. There, entry 623 reads entry 0 and entries from 227 onward read entries already rewritten in the same round. Errors in that region only show up several hundred words after seeding. The bench therefore drains over 1300 words under random `m_tready` stalls and compares them with an independent whole-block model, and the stalls also exercise the hold rule. A start pulse is injected while the automatic pass runs, and a reseed is forced while a word is held.

// File: rtl/mt_pkg.sv
`timescale 1ns/1ps
package mt_pkg;
    localparam int MT_W  = 32;
    localparam int MT_N  = 624;
    localparam int MT_M  = 397;
    localparam int MT_AW = $clog2(MT_N);

    typedef logic [MT_W-1:0]  mt_word_t;
    typedef logic [MT_AW-1:0] mt_idx_t;

    localparam mt_word_t INIT_MULT = 32'd1812433253;
    localparam mt_word_t TWIST_XOR = 32'h9908B0DF;
    localparam mt_word_t TEMPER_B  = 32'h9D2C5680;
    localparam mt_word_t TEMPER_C  = 32'hEFC60000;
    localparam mt_word_t HI_MASK   = 32'h80000000;
    localparam mt_word_t LO_MASK   = 32'h7FFFFFFF;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SEED = 2'd1,
        ST_RUN  = 2'd2
    } gen_state_e;

    typedef struct packed {
        gen_state_e state;
        mt_idx_t    k;
        mt_idx_t    idx;
        mt_word_t   tdata;
        logic       tvalid;
    } gen_regs_t;
endpackage

// File: rtl/mt_state_ram.sv
`timescale 1ns/1ps
module mt_state_ram #(
    parameter int WIDTH = 32,
    parameter int DEPTH = 624,
    parameter int NRD   = 3,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic                       clk,
    input  logic                       we,
    input  logic [AW-1:0]              waddr,
    input  logic [WIDTH-1:0]           wdata,
    input  logic [NRD-1:0][AW-1:0]     raddr,
    output logic [NRD-1:0][WIDTH-1:0]  rdata
);
    logic [WIDTH-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    // asynchronous read ports, one per lookup the recurrence needs
    generate
        for (genvar g = 0; g < NRD; g++) begin : g_rd
            assign rdata[g] = mem[raddr[g]];
        end
    endgenerate
endmodule

// File: rtl/mt_serial_mul.sv
`timescale 1ns/1ps
module mt_serial_mul #(
    parameter int              W      = 32,
    parameter logic [W-1:0]    FACTOR = 32'd1812433253,
    localparam int             CW     = $clog2(W + 1)
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic [W-1:0] a,
    output logic         done,
    output logic [W-1:0] prod
);
    typedef struct packed {
        logic [W-1:0]  acc;
        logic [W-1:0]  mcand;
        logic [W-1:0]  mplier;
        logic [CW-1:0] cnt;
        logic          run;
        logic          done;
    } mul_regs_t;

    mul_regs_t q, d;

    always_comb begin
        d      = q;
        d.done = 1'b0;
        if (start) begin
            d.acc    = '0;
            d.mcand  = a;
            d.mplier = FACTOR;
            d.cnt    = CW'(W);
            d.run    = 1'b1;
        end else if (q.run) begin
            if (q.mplier[0]) begin
                d.acc = q.acc + q.mcand;
            end
            d.mcand  = q.mcand << 1;
            d.mplier = q.mplier >> 1;
            d.cnt    = q.cnt - 1'b1;
            if (q.cnt == CW'(1)) begin
                d.run  = 1'b0;
                d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign done = q.done;
    assign prod = q.acc;

    // R4: once started, the product needs every one of its W steps
    a_r4_full_span: assert property (@(posedge clk) disable iff (rst)
        (q.run && q.cnt > CW'(1) && !start) |=> q.run)
        else $error("multiplier stopped early");

    // R4: completion is a single-cycle pulse
    a_r4_done_pulse: assert property (@(posedge clk) disable iff (rst)
        q.done |=> !q.done)
        else $error("done held more than one cycle");
endmodule

// File: rtl/mt_twist.sv
`timescale 1ns/1ps
module mt_twist
    import mt_pkg::*;
(
    input  mt_word_t cur,
    input  mt_word_t nxt,
    input  mt_word_t far,
    output mt_word_t fresh
);
    mt_word_t y;

    always_comb begin
        y     = (cur & HI_MASK) | (nxt & LO_MASK);
        fresh = far ^ (y >> 1) ^ (y[0] ? TWIST_XOR : '0);
    end
endmodule

// File: rtl/mt_temper.sv
`timescale 1ns/1ps
module mt_temper
    import mt_pkg::*;
#(
    parameter int SH_U = 11,
    parameter int SH_S = 7,
    parameter int SH_T = 15,
    parameter int SH_L = 18
) (
    input  mt_word_t raw,
    output mt_word_t cooked
);
    mt_word_t s1, s2, s3;

    always_comb begin
        s1     = raw ^ (raw >> SH_U);
        s2     = s1 ^ ((s1 << SH_S) & TEMPER_B);
        s3     = s2 ^ ((s2 << SH_T) & TEMPER_C);
        cooked = s3 ^ (s3 >> SH_L);
    end
endmodule

// File: rtl/mt_stream_gen.sv
`timescale 1ns/1ps
module mt_stream_gen
    import mt_pkg::*;
#(
    parameter logic [31:0] DEFAULT_SEED = 32'd5489
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [31:0] seed_val,
    input  logic        seed_start,
    output logic        busy,
    output logic [31:0] m_tdata,
    output logic        m_tvalid,
    input  logic        m_tready
);
    localparam logic [MT_AW:0] N_EXT = (MT_AW+1)'(MT_N);
    localparam logic [MT_AW:0] M_EXT = (MT_AW+1)'(MT_M);
    localparam mt_idx_t        LAST  = MT_AW'(MT_N - 1);

    gen_regs_t q, d;

    // state array
    logic                       mem_we;
    mt_idx_t                    mem_waddr;
    mt_word_t                   mem_wdata;
    logic [2:0][MT_AW-1:0]      mem_raddr;
    logic [2:0][MT_W-1:0]       mem_rdata;

    // seed multiplier
    logic     mul_start;
    mt_word_t mul_a;
    logic     mul_done;
    mt_word_t mul_p;

    // regeneration path
    mt_idx_t        idx_p1, idx_pm;
    logic [MT_AW:0] sum_m;
    mt_word_t       fresh_word, tempered_word;

    // seeding path
    logic     seed_go;
    mt_word_t go_val, seed_word;

    mt_state_ram #(.WIDTH(MT_W), .DEPTH(MT_N), .NRD(3)) u_ram (
        .clk   (clk),
        .we    (mem_we),
        .waddr (mem_waddr),
        .wdata (mem_wdata),
        .raddr (mem_raddr),
        .rdata (mem_rdata)
    );

    mt_serial_mul #(.W(MT_W), .FACTOR(INIT_MULT)) u_mul (
        .clk   (clk),
        .rst   (rst),
        .start (mul_start),
        .a     (mul_a),
        .done  (mul_done),
        .prod  (mul_p)
    );

    mt_twist u_twist (
        .cur   (mem_rdata[0]),
        .nxt   (mem_rdata[1]),
        .far   (mem_rdata[2]),
        .fresh (fresh_word)
    );

    mt_temper u_temper (
        .raw    (fresh_word),
        .cooked (tempered_word)
    );

    // neighbour indices with wrap at the array end
    always_comb begin
        idx_p1 = (q.idx == LAST) ? '0 : q.idx + 1'b1;
        sum_m  = {1'b0, q.idx} + M_EXT;
        idx_pm = (sum_m >= N_EXT) ? MT_AW'(sum_m - N_EXT) : MT_AW'(sum_m);
        mem_raddr[0] = q.idx;
        mem_raddr[1] = idx_p1;
        mem_raddr[2] = idx_pm;
    end

    always_comb begin
        d         = q;
        mem_we    = 1'b0;
        mem_waddr = '0;
        mem_wdata = '0;
        mul_start = 1'b0;
        mul_a     = '0;
        seed_word = mul_p + mt_word_t'(q.k);

        // a request outside a pass, or the first read attempt, starts seeding
        seed_go = (q.state != ST_SEED) &&
                  (seed_start || (q.state == ST_IDLE && m_tready));
        go_val  = seed_start ? seed_val : DEFAULT_SEED;

        if (seed_go) begin
            mem_we    = 1'b1;
            mem_waddr = '0;
            mem_wdata = go_val;
            mul_start = 1'b1;
            mul_a     = go_val ^ (go_val >> 30);
            d.k       = MT_AW'(1);
            d.state   = ST_SEED;
            d.tvalid  = 1'b0;
        end else begin
            case (q.state)
                ST_SEED: begin
                    if (mul_done) begin
                        mem_we    = 1'b1;
                        mem_waddr = q.k;
                        mem_wdata = seed_word;
                        if (q.k == LAST) begin
                            d.state = ST_RUN;
                            d.idx   = '0;
                        end else begin
                            d.k       = q.k + 1'b1;
                            mul_start = 1'b1;
                            mul_a     = seed_word ^ (seed_word >> 30);
                        end
                    end
                end
                ST_RUN: begin
                    if (!q.tvalid || m_tready) begin
                        mem_we    = 1'b1;
                        mem_waddr = q.idx;
                        mem_wdata = fresh_word;
                        d.tdata   = tempered_word;
                        d.tvalid  = 1'b1;
                        d.idx     = idx_p1;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign busy     = (q.state == ST_SEED);
    assign m_tdata  = q.tdata;
    assign m_tvalid = q.tvalid;

    // R1: a stalled word is held unchanged
    a_r1_hold: assert property (@(posedge clk) disable iff (rst)
        (m_tvalid && !m_tready && !seed_start) |=> (m_tvalid && $stable(m_tdata)))
        else $error("stalled word changed");

    // R2: no bubble between words under continuous ready
    a_r2_back_to_back: assert property (@(posedge clk) disable iff (rst)
        (q.state == ST_RUN && m_tvalid && m_tready && !seed_start) |=> m_tvalid)
        else $error("gap in output stream");

    // R5: nothing is offered while the state is being filled
    a_r5_quiet_when_busy: assert property (@(posedge clk) disable iff (rst)
        busy |-> !m_tvalid)
        else $error("valid during seeding");

    // R6: a start request during a pass does not end or restart it
    a_r6_ignore_start: assert property (@(posedge clk) disable iff (rst)
        (busy && seed_start && !mul_done) |=> (busy && $stable(q.k)))
        else $error("start accepted while busy");

    // R7: first read attempt on an unseeded generator begins seeding
    a_r7_auto_seed: assert property (@(posedge clk) disable iff (rst)
        (q.state == ST_IDLE && m_tready) |=> busy)
        else $error("automatic seed not started");
endmodule

// File: tb/mt_stream_gen_test.sv
`timescale 1ns/1ps
module mt_stream_gen_test;
    logic        clk = 1'b0;
    logic        rst;
    logic [31:0] seed_val;
    logic        seed_start;
    logic        busy;
    logic [31:0] m_tdata;
    logic        m_tvalid;
    logic        m_tready;

    int total = 0;
    int bad   = 0;

    always #2.5 clk = ~clk;

    mt_stream_gen uut (
        .clk        (clk),
        .rst        (rst),
        .seed_val   (seed_val),
        .seed_start (seed_start),
        .busy       (busy),
        .m_tdata    (m_tdata),
        .m_tvalid   (m_tvalid),
        .m_tready   (m_tready)
    );

    // first words for seed 5489
    localparam logic [31:0] GOLD [8] = '{
        32'd3499211612, 32'd581869302, 32'd3890346734, 32'd3586334585,
        32'd545404204,  32'd4161255391, 32'd3922919429, 32'd949333985
    };

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0d exp=%0d", req, act, exp);
        end
    endtask

    // whole-block software model
    logic [31:0] mdl [624];
    int          mdl_i;

    task automatic mdl_seed(input logic [31:0] s);
        mdl[0] = s;
        for (int i = 1; i < 624; i++) begin
            logic [31:0] p;
            p = mdl[i-1];
            mdl[i] = 32'd1812433253 * (p ^ (p >> 30)) + 32'(i);
        end
        mdl_i = 624;
    endtask

    task automatic mdl_next(output logic [31:0] w);
        logic [31:0] y;
        if (mdl_i >= 624) begin
            for (int j = 0; j < 624; j++) begin
                logic [31:0] t;
                t = (mdl[j] & 32'h80000000) | (mdl[(j+1)%624] & 32'h7FFFFFFF);
                mdl[j] = mdl[(j+397)%624] ^ (t >> 1) ^ (t[0] ? 32'h9908B0DF : 32'h0);
            end
            mdl_i = 0;
        end
        y = mdl[mdl_i];
        mdl_i++;
        y = y ^ (y >> 11);
        y = y ^ ((y << 7) & 32'h9D2C5680);
        y = y ^ ((y << 15) & 32'hEFC60000);
        y = y ^ (y >> 18);
        w = y;
    endtask

    // entered and left at a falling edge; leaves ready low
    task automatic read_words(input int n, input bit stall, input string req);
        int          got = 0;
        bit          hold_pending = 0;
        logic [31:0] held = '0;
        logic [31:0] exp;
        while (got < n) begin
            if (hold_pending) begin
                chk(m_tvalid && m_tdata == held, "R1 hold under stall", m_tdata, held);
                hold_pending = 0;
            end
            m_tready = stall ? ($urandom_range(0, 3) != 0) : 1'b1;
            if (m_tvalid && m_tready) begin
                mdl_next(exp);
                chk(m_tdata == exp, req, m_tdata, exp);
                got++;
            end else if (m_tvalid) begin
                held = m_tdata;
                hold_pending = 1;
            end
            @(negedge clk);
        end
        m_tready = 1'b0;
    endtask

    task automatic wait_seed(output int cycles);
        int viol = 0;
        cycles = 0;
        while (busy) begin
            if (m_tvalid) viol++;
            @(negedge clk);
            cycles++;
        end
        chk(viol == 0, "R5 valid low while busy", 32'(viol), 32'd0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog act=%0d exp=%0d", 0, 1);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int cyc;
        int waits;
        rst        = 1'b1;
        seed_val   = '0;
        seed_start = 1'b0;
        m_tready   = 1'b0;
        repeat (4) @(negedge clk);
        chk(!busy && !m_tvalid, "R5 reset outputs", {30'd0, busy, m_tvalid}, 32'd0);
        rst = 1'b0;

        // R7: no read attempt, no seeding
        repeat (20) @(negedge clk);
        chk(!busy && !m_tvalid, "R7 idle without ready", {30'd0, busy, m_tvalid}, 32'd0);

        // R7: first read attempt triggers the default seed
        m_tready = 1'b1;
        @(negedge clk);
        chk(busy, "R7 auto seed starts", {31'd0, busy}, 32'd1);

        // R6: a start pulse during the pass is dropped
        seed_val   = 32'd12345;
        seed_start = 1'b1;
        @(negedge clk);
        seed_start = 1'b0;
        chk(busy, "R6 busy kept", {31'd0, busy}, 32'd1);

        wait_seed(cyc);
        chk(cyc >= 623 * 32, "R4 serial seeding length", 32'(cyc), 32'(623 * 32));
        mdl_seed(32'd5489);

        // table walk: first words, R7/R9, and back-to-back timing R2
        for (int e = 0; e < 8; e++) begin
            logic [31:0] exp;
            waits = 0;
            while (!m_tvalid) begin
                @(negedge clk);
                waits++;
            end
            mdl_next(exp);
            chk(m_tdata == GOLD[e], "R9 tempered table word", m_tdata, GOLD[e]);
            chk(m_tdata == exp, "R6 seed unchanged by ignored start", m_tdata, exp);
            if (e > 0) chk(waits == 0, "R2 one word per cycle", 32'(waits), 32'd0);
            @(negedge clk);
        end

        // R8: cross the 624-word regeneration boundary twice with stalls
        read_words(1300, 1'b1, "R8 regeneration sequence");

        // R11/R3: reseed while a word is held
        repeat (2) @(negedge clk);
        chk(m_tvalid, "R1 word pending before reseed", {31'd0, m_tvalid}, 32'd1);
        seed_val   = 32'hDEADBEEF;
        seed_start = 1'b1;
        @(negedge clk);
        seed_start = 1'b0;
        chk(!m_tvalid && busy, "R11 reseed withdraws word", {30'd0, busy, m_tvalid}, 32'd2);
        wait_seed(cyc);
        mdl_seed(32'hDEADBEEF);
        read_words(700, 1'b1, "R3 explicit seed sequence");

        // R10: reset forgets the seed, auto seed applies again
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        chk(!busy && !m_tvalid, "R10 outputs after reset", {30'd0, busy, m_tvalid}, 32'd0);
        m_tready = 1'b1;
        @(negedge clk);
        chk(busy, "R10 auto seed after reset", {31'd0, busy}, 32'd1);
        wait_seed(cyc);
        while (!m_tvalid) @(negedge clk);
        chk(m_tdata == 32'd3499211612, "R10 first word after reset", m_tdata, 32'd3499211612);
        @(negedge clk);
        m_tready = 1'b0;

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule